// File: doc/BRIEF.md
# Bulk-IN Endpoint Transmit Packet Buffer with DMA Pacing

This block sits between a DMA engine and the host-facing transmit path of one bulk-IN endpoint. It owns two packet buffers of 64 bytes each, used alternately. The DMA engine writes bytes into the buffer that is open for writing, one byte per cycle, and is paced by a request output. The request is raised whenever software has armed the DMA path and an open buffer can take data. It stays high after the last byte of a transfer has been written. Software drops it by clearing the enable.

When the 64th byte lands in a buffer, the block closes that buffer as a ready packet by itself. A transfer whose length is a multiple of 64 therefore needs no software action. A shorter tail is closed by a software commit strobe, typically issued from the DMA completion interrupt. A strobe on an empty buffer produces a zero-length packet. A strobe that finds no open buffer, or that lands on the same cycle as the 64th byte, is flagged and has no other effect.

The host side sees the oldest ready packet: its length and a byte at a time through a pop strobe. A done strobe releases the buffer. The write side moves to the other buffer as soon as it is free.

Top module: `ep_tx_dma_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both buffers become empty with no ready packet, the DMA enable is cleared, and writing restarts in buffer 0. After reset, `dma_req`, `rd_avail` and `pkt_err` read 0.
- R2: `dma_req` is 1 whenever the enable is set and the buffer selected for writing is open. This holds with no write pending. It is 0 while the enable is clear.
- R3: A `dma_en_clr` pulse makes `dma_req` 0 from the next cycle. When set and clear arrive together, clear wins.
- R4: A write of the 64th byte into the open buffer closes it as a 64-byte ready packet at that same edge, with no software strobe.
- R5: A buffer holding 1 to 63 bytes stays unready, with `rd_avail` 0, until `pkt_commit` closes it. Its packet then reports exactly the bytes written.
- R6: `pkt_commit` on an open, empty buffer produces a ready packet with `rd_len` 0.
- R7: `pkt_commit` while no buffer is open for writing, or in the cycle that writes the 64th byte, sets `pkt_err` to 1 in the next cycle. It adds no packet and changes no length or data.
- R8: After a buffer closes, writing moves to the other buffer at once if that buffer is empty. If both buffers hold ready packets, `dma_req` is 0 and writes are ignored. The request returns one cycle after the host releases a buffer.
- R9: `rd_avail` and `rd_len` describe the oldest ready packet. `rd_data` shows its byte at the read position, which starts at 0 and advances by one per `rd_pop` cycle. `rd_done` releases the packet, and the next one, if any, shows in the following cycle.
- R10: Packets reach the host in the order they were closed, with bytes in write order. A 150-byte transfer arrives as 64, 64 and 22 bytes.
- R11: A buffer never holds more than 64 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_en_set | input | 1 | Software pulse that arms the DMA request |
| dma_en_clr | input | 1 | Software pulse that disarms the DMA request (wins over set) |
| dma_req | output | 1 | Request to the DMA engine for more bytes |
| dma_wr_valid | input | 1 | DMA byte write strobe |
| dma_wr_data | input | 8 | DMA byte |
| pkt_commit | input | 1 | Software strobe that closes a short or empty packet |
| pkt_err | output | 1 | Commit strobe was refused (one cycle after the strobe) |
| rd_avail | output | 1 | A ready packet is presented to the host side |
| rd_len | output | 7 | Byte count of the presented packet, 0 to 64 |
| rd_data | output | 8 | Byte at the current read position |
| rd_pop | input | 1 | Advance the read position by one byte |
| rd_done | input | 1 | Release the presented packet |

## Verification
A wrong buffer selection or a stale ready flag shows up as a wrong `rd_len` or a missing `rd_avail` on the very next packet. The bench catches it within one packet time, because every byte is checked against a value computed from its position in the transfer. A commit that fires one byte early or late moves a byte across a packet boundary, which the sweep over every transfer length from 0 to 150 exposes as a length mismatch. A request that fails to fall or to return is seen at the port in the cycle after the enable is cleared or after the host releases a buffer.

// File: rtl/ep_tx_pkg.sv
// Package: shared types and helpers for the endpoint transmit buffer.
// Assumes exactly two buffers used alternately; the selector is one bit.
package ep_tx_pkg;

    localparam int NUM_BUFS = 2;

    typedef logic buf_sel_t;

    // Returns the index of the partner buffer.
    function automatic buf_sel_t other_buf(input buf_sel_t s);
        return ~s;
    endfunction

endpackage

// File: rtl/tx_pkt_buf.sv
// Module: one packet buffer with its byte count and ready flag.
// Bytes are appended at the current count while the buffer is open (not
// ready) and not full. A commit marks it ready; a free empties it.
// Assumes the controllers never raise commit and free together.
module tx_pkt_buf #(
    parameter int PKT_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              free,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              ready
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_BYTES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PKT_BYTES - 1);

    logic [DATA_W-1:0] mem [PKT_BYTES];
    logic              accept;

    // A write lands only on an open buffer with room left.
    assign accept = wr_en && !ready && (count != FULL_CNT);

    // Byte storage, written at the current fill position.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    // Fill count: cleared by reset or free, bumped by each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || free) begin
            count <= '0;
        end else if (accept) begin
            count <= count + 1'b1;
        end
    end

    // Ready flag: set by commit, cleared by reset or free.
    always_ff @(posedge clk) begin
        if (!rst_n || free) begin
            ready <= 1'b0;
        end else if (commit) begin
            ready <= 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];

    // R11: the fill count stays within one packet.
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4: the last byte of a packet closes the buffer in the same edge.
    p_full_commits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ready && count == LAST_CNT) |=> (ready && count == FULL_CNT));

    // R9: a released buffer is empty and open one cycle later.
    p_free_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free |=> (count == '0 && !ready));

    // R8: a ready buffer ignores writes.
    p_hold_when_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !free) |=> $stable(count));

endmodule

// File: rtl/tx_wr_ctrl.sv
// Module: write-side control. Holds the DMA enable, picks the buffer being
// filled, decides when it closes (64th byte or software strobe) and flags
// refused strobes. Assumes the buffers report their count and ready flag.
module tx_wr_ctrl #(
    parameter int PKT_BYTES = 64,
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_set,
    input  logic                en_clr,
    input  logic                wr_valid,
    input  logic                sw_commit,
    input  logic [CNT_W-1:0]    cnt_w,
    input  logic                ready_w,
    input  logic                ready_o,
    output ep_tx_pkg::buf_sel_t wsel,
    output logic                wr_acc,
    output logic                commit,
    output logic                dma_req,
    output logic                pkt_err
);

    import ep_tx_pkg::*;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PKT_BYTES - 1);

    logic en_r;
    logic full_hit;
    logic refuse;
    logic move_on;

    // A byte is taken only while the selected buffer is open.
    assign wr_acc   = wr_valid && !ready_w;
    assign full_hit = wr_acc && (cnt_w == LAST_CNT);
    assign commit   = full_hit || (sw_commit && !ready_w);
    assign refuse   = sw_commit && (ready_w || full_hit);
    assign move_on  = (commit || ready_w) && !ready_o;
    assign dma_req  = en_r && !ready_w;

    // DMA enable register; clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n || en_clr) begin
            en_r <= 1'b0;
        end else if (en_set) begin
            en_r <= 1'b1;
        end
    end

    // Write buffer selector; moves to the partner once it is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel <= 1'b0;
        end else if (move_on) begin
            wsel <= other_buf(wsel);
        end
    end

    // Error pulse for a refused commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_err <= 1'b0;
        end else begin
            pkt_err <= refuse;
        end
    end

    // R3: a clear pulse silences the request next cycle.
    p_clr_drops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !dma_req);

    // R7: a refused strobe is reported in the following cycle.
    p_refuse_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_commit && ready_w) |=> pkt_err);

endmodule

// File: rtl/tx_rd_ctrl.sv
// Module: host-side read control. Tracks which buffer holds the oldest
// ready packet and the byte position inside it; releases it on done.
// Assumes packets close alternately, so the oldest simply toggles.
module tx_rd_ctrl #(
    parameter int PKT_BYTES = 64,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ready_r,
    input  logic [CNT_W-1:0]    cnt_r,
    input  logic                rd_pop,
    input  logic                rd_done,
    output ep_tx_pkg::buf_sel_t rsel,
    output logic [AW-1:0]       rd_addr,
    output logic                free_r
);

    import ep_tx_pkg::*;

    logic [CNT_W-1:0] rptr;
    logic             step;

    assign step    = rd_pop && ready_r && (rptr < cnt_r);
    assign free_r  = rd_done && ready_r;
    assign rd_addr = rptr[AW-1:0];

    // Read position: restarts on release, advances on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n || free_r) begin
            rptr <= '0;
        end else if (step) begin
            rptr <= rptr + 1'b1;
        end
    end

    // Oldest-packet selector; toggles on each release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel <= 1'b0;
        end else if (free_r) begin
            rsel <= other_buf(rsel);
        end
    end

    // R9: the read position never passes the packet length.
    p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_r |-> (rptr <= cnt_r));

endmodule

// File: rtl/ep_tx_dma_fifo.sv
// Module: top of the bulk-IN transmit buffer. Two packet buffers, a write
// controller facing DMA and software, and a read controller facing the
// host side. Assumes one DMA byte per cycle at most.
module ep_tx_dma_fifo #(
    parameter int PKT_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en_set,
    input  logic              dma_en_clr,
    output logic              dma_req,
    input  logic              dma_wr_valid,
    input  logic [DATA_W-1:0] dma_wr_data,
    input  logic              pkt_commit,
    output logic              pkt_err,
    output logic              rd_avail,
    output logic [CNT_W-1:0]  rd_len,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_pop,
    input  logic              rd_done
);

    import ep_tx_pkg::*;

    buf_sel_t          wsel;
    buf_sel_t          rsel;
    logic              wr_acc;
    logic              commit;
    logic              free_r;
    logic [AW-1:0]     rd_addr;
    logic [CNT_W-1:0]  cnt  [NUM_BUFS];
    logic              rdy  [NUM_BUFS];
    logic [DATA_W-1:0] rdat [NUM_BUFS];

    // One buffer per slot, steered by the two selectors.
    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
        tx_pkt_buf #(
            .PKT_BYTES (PKT_BYTES),
            .DATA_W    (DATA_W)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_acc && (wsel == buf_sel_t'(b))),
            .wr_data (dma_wr_data),
            .commit  (commit && (wsel == buf_sel_t'(b))),
            .free    (free_r && (rsel == buf_sel_t'(b))),
            .rd_addr (rd_addr),
            .rd_data (rdat[b]),
            .count   (cnt[b]),
            .ready   (rdy[b])
        );
    end

    tx_wr_ctrl #(
        .PKT_BYTES (PKT_BYTES)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (dma_en_set),
        .en_clr    (dma_en_clr),
        .wr_valid  (dma_wr_valid),
        .sw_commit (pkt_commit),
        .cnt_w     (cnt[wsel]),
        .ready_w   (rdy[wsel]),
        .ready_o   (rdy[other_buf(wsel)]),
        .wsel      (wsel),
        .wr_acc    (wr_acc),
        .commit    (commit),
        .dma_req   (dma_req),
        .pkt_err   (pkt_err)
    );

    tx_rd_ctrl #(
        .PKT_BYTES (PKT_BYTES)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_r (rdy[rsel]),
        .cnt_r   (cnt[rsel]),
        .rd_pop  (rd_pop),
        .rd_done (rd_done),
        .rsel    (rsel),
        .rd_addr (rd_addr),
        .free_r  (free_r)
    );

    assign rd_avail = rdy[rsel];
    assign rd_len   = cnt[rsel];
    assign rd_data  = rdat[rsel];

    // R8: with both buffers holding packets, no request is made.
    p_both_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy[0] && rdy[1]) |-> !dma_req);

endmodule

// File: tb/ep_tx_dma_fifo_test.sv
// Bench: directed checks plus a sweep over every transfer length 0..150
// with a DMA writer and a host reader running side by side.
module ep_tx_dma_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en_set = 1'b0;
    logic       dma_en_clr = 1'b0;
    logic       dma_req;
    logic       dma_wr_valid = 1'b0;
    logic [7:0] dma_wr_data = '0;
    logic       pkt_commit = 1'b0;
    logic       pkt_err;
    logic       rd_avail;
    logic [6:0] rd_len;
    logic [7:0] rd_data;
    logic       rd_pop = 1'b0;
    logic       rd_done = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2ns clk = ~clk;

    ep_tx_dma_fifo uut (
        .clk (clk), .rst_n (rst_n),
        .dma_en_set (dma_en_set), .dma_en_clr (dma_en_clr),
        .dma_req (dma_req), .dma_wr_valid (dma_wr_valid),
        .dma_wr_data (dma_wr_data), .pkt_commit (pkt_commit),
        .pkt_err (pkt_err), .rd_avail (rd_avail), .rd_len (rd_len),
        .rd_data (rd_data), .rd_pop (rd_pop), .rd_done (rd_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_set();
        dma_en_set = 1'b1; @(negedge clk); dma_en_set = 1'b0;
    endtask

    task automatic pulse_clr();
        dma_en_clr = 1'b1; @(negedge clk); dma_en_clr = 1'b0;
    endtask

    task automatic pulse_commit();
        pkt_commit = 1'b1; @(negedge clk); pkt_commit = 1'b0;
    endtask

    // DMA model: one byte per requested cycle, data = base + index.
    task automatic dma_push(input int n, input int base);
        int i = 0;
        while (i < n) begin
            if (dma_req) begin
                dma_wr_valid = 1'b1;
                dma_wr_data  = 8'(base + i);
                i++;
            end else begin
                dma_wr_valid = 1'b0;
            end
            @(negedge clk);
        end
        dma_wr_valid = 1'b0;
    endtask

    // Host model: wait for a packet, check length and bytes, release it.
    task automatic host_take(input int exp_len, input int base, input string req);
        while (!rd_avail) @(negedge clk);
        chk(req, int'(rd_len), exp_len);
        for (int j = 0; j < exp_len; j++) begin
            chk("R10", int'(rd_data), (base + j) & 255);
            rd_pop = 1'b1;
            @(negedge clk);
        end
        rd_pop  = 1'b0;
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", int'(dma_req), 0);
        chk("R1", int'(rd_avail), 0);
        chk("R1", int'(pkt_err), 0);

        // R2: request with nothing pending, held while armed
        pulse_set();
        chk("R2", int'(dma_req), 1);
        repeat (3) @(negedge clk);
        chk("R2", int'(dma_req), 1);

        // R3: clear drops the request; clear beats set
        pulse_clr();
        chk("R3", int'(dma_req), 0);
        dma_en_set = 1'b1; dma_en_clr = 1'b1;
        @(negedge clk);
        dma_en_set = 1'b0; dma_en_clr = 1'b0;
        chk("R3", int'(dma_req), 0);

        // R6: zero-length packet, and R8 immediate switch
        pulse_set();
        pulse_commit();
        chk("R6", int'(rd_avail), 1);
        chk("R6", int'(rd_len), 0);
        chk("R8", int'(dma_req), 1);
        host_take(0, 0, "R6");

        // R8 and R7: fill both buffers, then a refused strobe and a stray byte
        dma_push(128, 8'h40);
        chk("R8", int'(dma_req), 0);
        chk("R4", int'(rd_len), 64);
        dma_wr_valid = 1'b1; dma_wr_data = 8'hEE; pkt_commit = 1'b1;
        @(negedge clk);
        dma_wr_valid = 1'b0; pkt_commit = 1'b0;
        chk("R7", int'(pkt_err), 1);
        chk("R7", int'(rd_len), 64);
        host_take(64, 8'h40, "R4");
        chk("R8", int'(dma_req), 0);
        @(negedge clk);
        chk("R8", int'(dma_req), 1);
        host_take(64, 8'h80, "R8");
        chk("R7", int'(pkt_err), 0);

        // R7: strobe coinciding with the 64th byte
        dma_push(63, 8'h10);
        dma_wr_valid = 1'b1; dma_wr_data = 8'(8'h10 + 63); pkt_commit = 1'b1;
        @(negedge clk);
        dma_wr_valid = 1'b0; pkt_commit = 1'b0;
        chk("R7", int'(pkt_err), 1);
        chk("R4", int'(rd_len), 64);
        host_take(64, 8'h10, "R11");
        chk("R7", int'(rd_avail), 0);

        // R5: short packet waits for the strobe
        dma_push(10, 8'h30);
        repeat (4) @(negedge clk);
        chk("R5", int'(rd_avail), 0);
        pulse_commit();
        chk("R5", int'(rd_len), 10);
        host_take(10, 8'h30, "R5");
        pulse_clr();

        // R9, R10: every length 0..150, writer and reader concurrent
        for (int len = 0; len <= 150; len++) begin
            int seed;
            int tail;
            int npk;
            seed = (len * 3) & 255;
            tail = len % 64;
            npk  = len / 64 + ((tail != 0 || len == 0) ? 1 : 0);
            pulse_set();
            fork
                begin
                    dma_push(len, seed);
                    if (tail != 0 || len == 0) pulse_commit();
                end
                begin
                    for (int k = 0; k < npk; k++) begin
                        if (k < len / 64)
                            host_take(64, seed + 64 * k, "R4");
                        else
                            host_take(tail, seed + 64 * k, "R9");
                    end
                end
            join
            chk("R9", int'(rd_avail), 0);
            pulse_clr();
            chk("R3", int'(dma_req), 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule